// File: doc/BRIEF.md
# Per-Channel Threshold Auto-Trigger with Over-Threshold Count

This block watches several digitized input channels and raises a local trigger for any channel whose signal moves past a programmable level and stays there long enough. Samples arrive four at a time for every channel in one beat (a quartet), so each channel makes its level decision once per beat. Each channel has its own level, its own direction (look for values above or below the level) and its own persistence setting. The persistence setting is the number of consecutive passing quartets needed before the trigger is taken.

Besides the trigger pulses, the block shows which enabled channels are currently past their level and how many of them there are. A system-level majority trigger or monitor can use that count. An enable mask takes a channel out of both the triggers and the count.

The sample stream uses valid/ready. `smp_ready` is always high, so the block never applies back-pressure and a beat is consumed in every cycle that `smp_valid` is high. A cycle with `smp_valid` low is not a quartet: per-channel state holds and no pulse is produced. Thresholds, persistence, direction and enable are plain static control inputs.

Top module: `chan_autotrig`

## Requirements
- R1: A quartet passes for a channel when at least one of its four samples is strictly beyond the threshold. With direction bit 1 that means greater than the threshold; with direction bit 0 it means less than the threshold. A sample equal to the threshold never passes.
- R2: The over-threshold flag of an enabled channel shows the result of its most recent accepted quartet, starting in the cycle after acceptance. It holds while `smp_valid` is low.
- R3: A channel pulses its trigger in the cycle after the accepted quartet that completes its Nth consecutive passing quartet. A persistence value of 0 behaves as 1.
- R4: A failing quartet resets the channel's run of passing quartets to zero, so a new run must again reach the persistence count.
- R5: Only one trigger is issued per excursion. More passing quartets after a trigger produce no further pulse until a failing quartet re-arms the channel.
- R6: A trigger pulse lasts exactly one cycle, and there is no pulse in a cycle that follows a cycle with `smp_valid` low.
- R7: A disabled channel issues no trigger and shows a flag of 0. A quartet accepted while the channel is disabled clears its run and re-arms it.
- R8: `over_count` equals, in the same cycle, the number of set bits of `over_flag`. `over_flag` is the stored flags masked by the current enable.
- R9: After reset all flags, pulses and the count are zero, and `smp_ready` is high.
- R10: Channels are independent; the behaviour of one channel does not depend on any other channel's samples or settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A quartet for all channels is present |
| smp_ready | output | 1 | Always 1; the block accepts every beat |
| smp_data | input | NUM_CH*4*SAMP_W | Channel c, slot k at bits [(c*4+k)*SAMP_W +: SAMP_W] |
| thresh | input | NUM_CH*SAMP_W | Per-channel level, channel c at [c*SAMP_W +: SAMP_W] |
| persist_n | input | NUM_CH*PER_W | Per-channel consecutive-quartet count |
| dir_up | input | NUM_CH | 1 = above level passes, 0 = below level passes |
| ch_enable | input | NUM_CH | Per-channel enable |
| trig_pulse | output | NUM_CH | One-cycle trigger per channel |
| over_flag | output | NUM_CH | Enabled channels whose last quartet passed |
| over_count | output | $clog2(NUM_CH+1) | Number of set bits of over_flag |

## Verification
On every cycle, the embedded assertions check the following: pulses are one cycle long; a pulse appears only with a passing flag; a failing or disabled quartet leaves no pulse; per-channel state is frozen when no beat is present; and the count matches the flag vector. Only the bench's scenarios can show several things: that a trigger comes on exactly the Nth passing quartet and not earlier, that a failing quartet restarts the run, that equality with the level does not pass, and that re-arming happens once per excursion. They also show that channels with different persistence and direction settings do not interact. The bench covers these with directed sequences and a long sweep in which persistence, direction, enable and beat gaps vary.

// File: rtl/atg_pkg.sv
package atg_pkg;
  localparam int QUAD = 4;
endpackage

// File: rtl/atg_quartet_cmp.sv
module atg_quartet_cmp
  import atg_pkg::*;
#(
  parameter int SAMP_W = 14
) (
  input  logic [QUAD*SAMP_W-1:0] quartet,
  input  logic [SAMP_W-1:0]      level,
  input  logic                   up,
  output logic                   pass
);
  logic [QUAD-1:0] beyond;

  for (genvar k = 0; k < QUAD; k++) begin : g_slot
    logic [SAMP_W-1:0] s;
    assign s = quartet[k*SAMP_W +: SAMP_W];
    assign beyond[k] = up ? (s > level) : (s < level);
  end

  assign pass = |beyond;
endmodule

// File: rtl/atg_persist.sv
module atg_persist #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             en,
  input  logic             pass,
  input  logic [PER_W-1:0] nth,
  output logic             trig,
  output logic             over
);
  logic [PER_W-1:0] run_q;
  logic             armed_q;
  logic [PER_W-1:0] need;
  logic [PER_W-1:0] run_nx;
  logic             hit;

  assign need   = (nth == '0) ? PER_W'(1) : nth;
  assign run_nx = (run_q < need) ? run_q + PER_W'(1) : run_q;
  assign hit    = armed_q && (run_nx >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b1;
      over    <= 1'b0;
      trig    <= 1'b0;
    end else if (!acc) begin
      trig <= 1'b0;
    end else if (!en || !pass) begin
      run_q   <= '0;
      armed_q <= 1'b1;
      over    <= 1'b0;
      trig    <= 1'b0;
    end else begin
      run_q <= run_nx;
      over  <= 1'b1;
      trig  <= hit;
      if (hit) armed_q <= 1'b0;
    end
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  p_pulse_with_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> over);
  p_fail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pass) |=> (!trig && !over));
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !en) |=> (!trig && !over));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(over) && !trig));
endmodule

// File: rtl/atg_popcount.sv
module atg_popcount #(
  parameter int N = 8,
  localparam int OW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [OW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + OW'(bits[i]);
  end
endmodule

// File: rtl/chan_autotrig.sv
module chan_autotrig
  import atg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SAMP_W = 14,
  parameter int PER_W  = 8,
  localparam int CW    = $clog2(NUM_CH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_valid,
  output logic                          smp_ready,
  input  logic [NUM_CH*QUAD*SAMP_W-1:0] smp_data,
  input  logic [NUM_CH*SAMP_W-1:0]      thresh,
  input  logic [NUM_CH*PER_W-1:0]       persist_n,
  input  logic [NUM_CH-1:0]             dir_up,
  input  logic [NUM_CH-1:0]             ch_enable,
  output logic [NUM_CH-1:0]             trig_pulse,
  output logic [NUM_CH-1:0]             over_flag,
  output logic [CW-1:0]                 over_count
);
  localparam int QW = QUAD * SAMP_W;

  logic [NUM_CH-1:0] pass;
  logic [NUM_CH-1:0] over_q;

  assign smp_ready = 1'b1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    atg_quartet_cmp #(.SAMP_W(SAMP_W)) u_cmp (
      .quartet (smp_data[c*QW +: QW]),
      .level   (thresh[c*SAMP_W +: SAMP_W]),
      .up      (dir_up[c]),
      .pass    (pass[c])
    );

    atg_persist #(.PER_W(PER_W)) u_per (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (smp_valid),
      .en    (ch_enable[c]),
      .pass  (pass[c]),
      .nth   (persist_n[c*PER_W +: PER_W]),
      .trig  (trig_pulse[c]),
      .over  (over_q[c])
    );
  end

  assign over_flag = over_q & ch_enable;

  atg_popcount #(.N(NUM_CH)) u_cnt (
    .bits  (over_flag),
    .count (over_count)
  );

  p_count_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(over_count) == $countones(over_flag));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(over_count) <= NUM_CH);
  p_pulse_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse != '0) |-> $past(smp_valid));
endmodule

// File: tb/tb_chan_autotrig.sv
module tb_chan_autotrig;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int SW = 14;
  localparam int PW = 8;
  localparam int CW = $clog2(NC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [NC*4*SW-1:0] smp_data;
  logic [NC*SW-1:0] thresh;
  logic [NC*PW-1:0] persist_n;
  logic [NC-1:0] dir_up = '1;
  logic [NC-1:0] ch_enable = '1;
  logic [NC-1:0] trig_pulse, over_flag;
  logic [CW-1:0] over_count;

  logic [SW-1:0] smp [NC][4];
  logic [SW-1:0] th [NC];
  logic [PW-1:0] nth [NC];

  int m_run [NC];
  bit m_arm [NC];
  bit m_ov [NC];
  bit m_tg [NC];

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      thresh[c*SW +: SW] = th[c];
      persist_n[c*PW +: PW] = nth[c];
      for (int k = 0; k < 4; k++) smp_data[(c*4+k)*SW +: SW] = smp[c][k];
    end
  end

  chan_autotrig #(.NUM_CH(NC), .SAMP_W(SW), .PER_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .thresh(thresh), .persist_n(persist_n),
    .dir_up(dir_up), .ch_enable(ch_enable), .trig_pulse(trig_pulse),
    .over_flag(over_flag), .over_count(over_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit q_pass(input int c);
    bit p = 0;
    for (int k = 0; k < 4; k++)
      p |= dir_up[c] ? (smp[c][k] > th[c]) : (smp[c][k] < th[c]);
    return p;
  endfunction

  task automatic model_accept();
    for (int c = 0; c < NC; c++) begin
      int need = (nth[c] == 0) ? 1 : int'(nth[c]);
      if (!ch_enable[c] || !q_pass(c)) begin
        m_run[c] = 0; m_arm[c] = 1; m_ov[c] = 0; m_tg[c] = 0;
      end else begin
        if (m_run[c] < need) m_run[c]++;
        m_ov[c] = 1;
        m_tg[c] = m_arm[c] && (m_run[c] >= need);
        if (m_tg[c]) m_arm[c] = 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    int cnt = 0;
    for (int c = 0; c < NC; c++) begin
      bit eo = m_ov[c] & ch_enable[c];
      cnt += int'(eo);
      check(trig_pulse[c] == m_tg[c], {tag, " trig"}, int'(trig_pulse[c]), int'(m_tg[c]));
      check(over_flag[c] == eo, {tag, " flag"}, int'(over_flag[c]), int'(eo));
    end
    check(int'(over_count) == cnt, {tag, " count R8"}, int'(over_count), cnt);
  endtask

  // drive one cycle; v=1 presents a quartet
  task automatic step(input bit v, input string tag);
    @(negedge clk);
    smp_valid = v;
    @(posedge clk);
    if (v) model_accept();
    else for (int c = 0; c < NC; c++) m_tg[c] = 0;
    #(CLK_PERIOD/4);
    compare(tag);
  endtask

  task automatic fill(input int c, input int v);
    for (int k = 0; k < 4; k++) smp[c][k] = SW'(v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      th[c] = SW'(1000); nth[c] = 1; fill(c, 1000);
      m_run[c] = 0; m_arm[c] = 1; m_ov[c] = 0; m_tg[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    check(trig_pulse == '0, "R9 trig", int'(trig_pulse), 0);
    check(over_flag == '0, "R9 flag", int'(over_flag), 0);
    check(over_count == '0, "R9 count", int'(over_count), 0);
    check(smp_ready == 1'b1, "R9 ready", int'(smp_ready), 1);

    // R1 equality never passes; one slot above passes (direction up)
    step(1, "R1");
    check(over_flag[0] == 1'b0, "R1 equal", int'(over_flag[0]), 0);
    smp[0][3] = SW'(1001);
    step(1, "R1");
    check(over_flag[0] == 1'b1, "R1 above", int'(over_flag[0]), 1);
    // R1 direction down: below passes, above does not
    dir_up[1] = 1'b0; fill(1, 1001); fill(0, 1000);
    step(1, "R1");
    check(over_flag[1] == 1'b0, "R1 down above", int'(over_flag[1]), 0);
    smp[1][0] = SW'(999);
    step(1, "R1");
    check(over_flag[1] == 1'b1, "R1 down below", int'(over_flag[1]), 1);
    fill(1, 1000);
    step(1, "R1");

    // R3 persistence 3 on channel 2, R4 restart, R5 single pulse, R6 one cycle
    nth[2] = 3; fill(2, 1200);
    step(1, "R3"); check(trig_pulse[2] == 0, "R3 q1", int'(trig_pulse[2]), 0);
    step(1, "R3"); check(trig_pulse[2] == 0, "R3 q2", int'(trig_pulse[2]), 0);
    fill(2, 900);
    step(1, "R4"); check(over_flag[2] == 0, "R4 fail", int'(over_flag[2]), 0);
    fill(2, 1200);
    step(1, "R4"); step(1, "R4");
    check(trig_pulse[2] == 0, "R4 q2 after restart", int'(trig_pulse[2]), 0);
    step(1, "R3"); check(trig_pulse[2] == 1, "R3 q3 fires", int'(trig_pulse[2]), 1);
    step(0, "R6"); check(trig_pulse[2] == 0, "R6 idle no pulse", int'(trig_pulse[2]), 0);
    check(over_flag[2] == 1, "R2 idle holds", int'(over_flag[2]), 1);
    step(1, "R5"); check(trig_pulse[2] == 0, "R5 no repeat", int'(trig_pulse[2]), 0);
    fill(2, 1000);
    step(1, "R5");
    fill(2, 1200); nth[2] = 0;
    step(1, "R5"); check(trig_pulse[2] == 1, "R5 rearm nth0", int'(trig_pulse[2]), 1);

    // R7 disabled channel with passing samples
    fill(3, 1500); ch_enable[3] = 1'b0;
    step(1, "R7"); step(1, "R7");
    check(trig_pulse[3] == 0, "R7 no trig", int'(trig_pulse[3]), 0);
    check(over_flag[3] == 0, "R7 flag", int'(over_flag[3]), 0);
    ch_enable[3] = 1'b1;
    step(1, "R7"); check(trig_pulse[3] == 1, "R7 fresh run", int'(trig_pulse[3]), 1);

    // R10/R2/R8 sweep: every channel varies settings independently
    for (int blk = 0; blk < 40; blk++) begin
      for (int c = 0; c < NC; c++) begin
        nth[c] = PW'((c + blk) % 6);
        dir_up[c] = ((c + blk) % 3) != 0;
        ch_enable[c] = ($urandom % 8) != 0;
        th[c] = SW'(2000 + 100 * c);
      end
      for (int q = 0; q < 100; q++) begin
        for (int c = 0; c < NC; c++) begin
          int delta = dir_up[c] ? 1 + int'($urandom % 3) : -(1 + int'($urandom % 3));
          bit want = ($urandom % 10) < 7;
          fill(c, int'(th[c]) - (dir_up[c] ? int'($urandom % 2) : -int'($urandom % 2)));
          if (want) smp[c][$urandom % 4] = SW'(int'(th[c]) + delta);
        end
        step(($urandom % 5) != 0, "R10");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule